// File: doc/BRIEF.md
# Reversible Gate Evaluator with Feedback Latch

This block evaluates a family of classic reversible logic gates on 4-line input vectors. A 3-bit gate code chooses the gate. Every gate is a one-to-one map from 16 input patterns to 16 output patterns, and each lane registers its result on the system clock. Lines are numbered A to D from the least significant bit of each 4-bit lane. Gates with fewer than four lines pass the spare lines through unchanged. The parameter `LANES` sets how many independent 4-line vectors are evaluated side by side. All lanes share the gate code.

A second path builds a level-sensitive storage element from a single mux-with-complement gate. Its second output is fed back into its second input, and the element is clocked so that it stays synchronous. The stored bit lives in a two-state machine. The states are `LS_LOW` and `LS_HIGH`. A step where the gate's feedback output is 1 in `LS_LOW` is the RISE transition. A step where it is 0 in `LS_HIGH` is the FALL transition. Any other step is the STAY transition. A Feynman gate whose second input is tied to 1 copies the stored bit and produces its complement.

Top module: `revgate_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `vec_out` becomes all zeros, the latch state becomes `LS_LOW`, `lat_q` is 0 and `lat_qn` is 1.
- R2: `vec_out` shows the gate result for the `gate_sel` and `vec_in` values sampled at the previous rising edge. In each lane, bit 0 is line A, bit 1 is B, bit 2 is C and bit 3 is D, on both input and output.
- R3: Code 0 (Feynman): A'=A and B'=A^B, while C and D pass through unchanged.
- R4: Code 1 (Toffoli): A'=A, B'=B and C'=(A&B)^C, while D passes through.
- R5: Code 2 (Fredkin): A'=A. B' is B when A=0 and C when A=1. C' is C when A=0 and B when A=1. D passes through.
- R6: Code 3 (Peres): A'=A, B'=A^B and C'=(A&B)^C, while D passes through.
- R7: Code 4 (double Peres): A'=A, B'=A^B, C'=A^B^D and D'=((A^B)&D)^(A&B)^C.
- R8: Code 5 (mux-with-complement): A'=A, B'=(~A&B)^(A&C), C'=B'^D and D'=(A&B)^~C.
- R9: Codes 6 and 7 return the input unchanged.
- R10: For every gate code, the 16 input patterns of a lane produce 16 distinct output patterns.
- R11: When `lat_en` is 1 at a rising edge, `lat_q` takes the value of `lat_d` after that edge.
- R12: When `lat_en` is 0 at a rising edge, `lat_q` keeps its value, whatever `lat_d` is.
- R13: `lat_qn` is always the complement of `lat_q`.
- R14: Each lane i uses only bits 4i..4i+3 of `vec_in` and drives only bits 4i..4i+3 of `vec_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| gate_sel | input | 3 | Gate code |
| vec_in | input | 4*LANES | Input lines, 4 per lane |
| vec_out | output | 4*LANES | Registered output lines, 4 per lane |
| lat_en | input | 1 | Latch enable |
| lat_d | input | 1 | Latch data |
| lat_q | output | 1 | Stored latch bit |
| lat_qn | output | 1 | Complement of the stored bit |

## Verification
The bench builds the block with `LANES=2`. The upper lane always receives the bitwise complement of the lower lane's pattern. A wiring fault that crosses, swaps or shares lane bits therefore shows up as an upper-lane mismatch, which a single lane could never expose. All 16 patterns are applied under each of the 8 gate codes. This sweep covers both the exhaustive bijection check and both identity codes. The latch sequence walks through RISE, FALL and STAY, including STAY while `lat_d` toggles.

// File: rtl/revgate_pkg.sv
package revgate_pkg;

    typedef enum logic [2:0] {
        GS_FEYN   = 3'd0,
        GS_TOFF   = 3'd1,
        GS_FRED   = 3'd2,
        GS_PERES  = 3'd3,
        GS_DPERES = 3'd4,
        GS_MUXC   = 3'd5,
        GS_PASS6  = 3'd6,
        GS_PASS7  = 3'd7
    } gate_sel_e;

    typedef enum logic {
        LS_LOW  = 1'b0,
        LS_HIGH = 1'b1
    } latch_st_e;

    localparam int LINES = 4;

    // Two-line controlled inversion: line B flips when A is set.
    function automatic logic [3:0] g_feyn(input logic [3:0] v);
        return {v[3], v[2], v[0] ^ v[1], v[0]};
    endfunction

    // Doubly controlled inversion of line C.
    function automatic logic [3:0] g_toff(input logic [3:0] v);
        return {v[3], (v[0] & v[1]) ^ v[2], v[1], v[0]};
    endfunction

    // Controlled exchange of lines B and C under A.
    function automatic logic [3:0] g_fred(input logic [3:0] v);
        logic b_o;
        logic c_o;
        b_o = (~v[0] & v[1]) ^ (v[0] & v[2]);
        c_o = (~v[0] & v[2]) ^ (v[0] & v[1]);
        return {v[3], c_o, b_o, v[0]};
    endfunction

    function automatic logic [3:0] g_peres(input logic [3:0] v);
        return {v[3], (v[0] & v[1]) ^ v[2], v[0] ^ v[1], v[0]};
    endfunction

    function automatic logic [3:0] g_dperes(input logic [3:0] v);
        logic ab_x;
        ab_x = v[0] ^ v[1];
        return {(ab_x & v[3]) ^ (v[0] & v[1]) ^ v[2], ab_x ^ v[3], ab_x, v[0]};
    endfunction

    // Mux on B/C under A, with an XOR copy onto D and a complemented product.
    function automatic logic [3:0] g_muxc(input logic [3:0] v);
        logic m;
        m = (~v[0] & v[1]) ^ (v[0] & v[2]);
        return {(v[0] & v[1]) ^ ~v[2], m ^ v[3], m, v[0]};
    endfunction

endpackage

// File: rtl/revgate_lane.sv
module revgate_lane
    import revgate_pkg::*;
(
    input  gate_sel_e         sel,
    input  logic [LINES-1:0]  din,
    output logic [LINES-1:0]  dout
);

    always_comb begin
        unique case (sel)
            GS_FEYN:   dout = g_feyn(din);
            GS_TOFF:   dout = g_toff(din);
            GS_FRED:   dout = g_fred(din);
            GS_PERES:  dout = g_peres(din);
            GS_DPERES: dout = g_dperes(din);
            GS_MUXC:   dout = g_muxc(din);
            GS_PASS6:  dout = din;
            GS_PASS7:  dout = din;
        endcase
    end

endmodule

// File: rtl/revgate_latch.sv
module revgate_latch
    import revgate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic d,
    output logic q,
    output logic qn
);

    latch_st_e   state_q;
    latch_st_e   state_d;
    logic [3:0]  fb_out;
    logic [3:0]  cp_out;
    logic        fb_next;
    logic        unused_garbage;

    // Gate lines: A=enable, B=stored bit (feedback), C=data, D=constant 0.
    assign fb_out  = g_muxc({1'b0, d, (state_q == LS_HIGH), en});
    assign fb_next = fb_out[1];

    // Next-state process: RISE, FALL or STAY chosen by the gate's feedback line.
    always_comb begin
        unique case (state_q)
            LS_LOW:  state_d = fb_next ? LS_HIGH : LS_LOW;
            LS_HIGH: state_d = fb_next ? LS_HIGH : LS_LOW;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= LS_LOW;
        else     state_q <= state_d;
    end

    // Output process: a Feynman copy with B tied high gives the bit and its complement.
    always_comb begin
        cp_out = g_feyn({2'b00, 1'b1, (state_q == LS_HIGH)});
        q      = cp_out[0];
        qn     = cp_out[1];
    end

    assign unused_garbage = ^{fb_out[3:2], fb_out[0], cp_out[3:2]};

    p_load_r11: assert property (@(posedge clk) disable iff (rst)
        (en) |=> (q == $past(d)));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> (q == $past(q)));

    p_complement_r13: assert property (@(posedge clk) disable iff (rst)
        (qn != q));

endmodule

// File: rtl/revgate_unit.sv
module revgate_unit
    import revgate_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         gate_sel,
    input  logic [4*LANES-1:0] vec_in,
    output logic [4*LANES-1:0] vec_out,
    input  logic               lat_en,
    input  logic               lat_d,
    output logic               lat_q,
    output logic               lat_qn
);

    localparam int DW = LINES * LANES;

    gate_sel_e       sel_e;
    logic [DW-1:0]   comb_out;

    assign sel_e = gate_sel_e'(gate_sel);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        revgate_lane u_lane (
            .sel  (sel_e),
            .din  (vec_in[i*LINES +: LINES]),
            .dout (comb_out[i*LINES +: LINES])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) vec_out <= '0;
        else     vec_out <= comb_out;
    end

    revgate_latch u_latch (
        .clk (clk),
        .rst (rst),
        .en  (lat_en),
        .d   (lat_d),
        .q   (lat_q),
        .qn  (lat_qn)
    );

    p_line_a_kept_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (vec_out[0] == $past(vec_in[0])));

    p_feyn_upper_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (gate_sel == 3'd0) |=> (vec_out[3:2] == $past(vec_in[3:2])));

    p_toff_b_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (gate_sel == 3'd1) |=> (vec_out[1] == $past(vec_in[1])));

    p_unused_identity_r9: assert property (@(posedge clk) disable iff (rst)
        (gate_sel >= 3'd6) |=> (vec_out == $past(vec_in)));

endmodule

// File: tb/revgate_unit_bench.sv
module revgate_unit_bench;

    localparam int LANES = 2;
    localparam int DW    = 4 * LANES;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    gate_sel = 3'd5;
    logic [DW-1:0] vec_in = 8'hA5;
    logic [DW-1:0] vec_out;
    logic          lat_en = 1'b1;
    logic          lat_d  = 1'b1;
    logic          lat_q;
    logic          lat_qn;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    revgate_unit #(.LANES(LANES)) u_revgate_unit (
        .clk      (clk),
        .rst      (rst),
        .gate_sel (gate_sel),
        .vec_in   (vec_in),
        .vec_out  (vec_out),
        .lat_en   (lat_en),
        .lat_d    (lat_d),
        .lat_q    (lat_q),
        .lat_qn   (lat_qn)
    );

    typedef struct {
        logic [7:0] exp;
        logic [2:0] sel;
        bit         bij;
    } item_t;

    item_t      sbq[$];
    logic [15:0] seen [8];

    // Reference model written from the requirement equations.
    function automatic logic [3:0] model(input logic [2:0] s, input logic [3:0] v);
        logic a, b, c, d, m;
        a = v[0]; b = v[1]; c = v[2]; d = v[3];
        m = a ? c : b;
        case (s)
            3'd0: return {d, c, a ^ b, a};
            3'd1: return {d, c ^ (a & b), b, a};
            3'd2: return {d, a ? b : c, a ? c : b, a};
            3'd3: return {d, c ^ (a & b), a ^ b, a};
            3'd4: return {(((a ^ b) & d) ^ (a & b) ^ c), a ^ b ^ d, a ^ b, a};
            3'd5: return {(a & b) ^ ~c, m ^ d, m, a};
            default: return v;
        endcase
    endfunction

    function automatic string tag(input logic [2:0] s);
        case (s)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check1(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] s, input logic [3:0] lo, input bit bij);
        item_t it;
        @(negedge clk);
        gate_sel = s;
        vec_in   = {~lo, lo};
        it.exp   = {model(s, ~lo), model(s, lo)};
        it.sel   = s;
        it.bij   = bij;
        sbq.push_back(it);
    endtask

    // Monitor: one item per cycle, compared after the register stage (R2).
    initial begin
        for (int s = 0; s < 8; s++) seen[s] = '0;
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                check1({tag(it.sel), "/R2 lane0"}, {4'h0, vec_out[3:0]}, {4'h0, it.exp[3:0]});
                check1("R14 lane1", {4'h0, vec_out[7:4]}, {4'h0, it.exp[7:4]});
                if (it.bij) begin
                    total++;
                    if (seen[it.sel][vec_out[3:0]]) begin
                        bad++;
                        $display("FAIL R10: code %0d repeats output actual=%h expected=unique",
                                 it.sel, vec_out[3:0]);
                    end
                    seen[it.sel][vec_out[3:0]] = 1'b1;
                end
            end
        end
    end

    task automatic lat_step(input logic en, input logic d, inout logic mq, input string req);
        @(negedge clk);
        lat_en = en;
        lat_d  = d;
        @(posedge clk);
        #2;
        if (en) mq = d;
        check1(req, {7'd0, lat_q}, {7'd0, mq});
        check1("R13", {7'd0, lat_qn}, {7'd0, ~mq});
    endtask

    initial begin
        logic mq;
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check1("R1 vec_out", vec_out, 8'h00);
        check1("R1 lat_q", {7'd0, lat_q}, 8'h00);
        check1("R1 lat_qn", {7'd0, lat_qn}, 8'h01);
        @(negedge clk);
        rst    = 1'b0;
        lat_en = 1'b0;

        // R2..R10, R14: every code over every pattern
        for (int s = 0; s < 8; s++)
            for (int p = 0; p < 16; p++)
                send(3'(s), 4'(p), 1'b1);
        // R2: back-to-back changes with a non-sequential pattern order
        send(3'd4, 4'hB, 1'b0);
        send(3'd2, 4'h6, 1'b0);
        send(3'd7, 4'h3, 1'b0);
        send(3'd0, 4'hE, 1'b0);
        repeat (3) @(posedge clk);
        #3;
        for (int s = 0; s < 8; s++)
            check1("R10 coverage", {7'd0, seen[s] == 16'hFFFF}, 8'h01);

        // Latch: R12 hold at 0 while data toggles, R11 load, RISE/FALL/STAY
        mq = 1'b0;
        lat_step(1'b0, 1'b1, mq, "R12 hold low");
        lat_step(1'b0, 1'b0, mq, "R12 hold low");
        lat_step(1'b1, 1'b1, mq, "R11 rise");
        lat_step(1'b0, 1'b0, mq, "R12 hold high");
        lat_step(1'b0, 1'b1, mq, "R12 hold high");
        lat_step(1'b0, 1'b0, mq, "R12 hold high");
        lat_step(1'b1, 1'b1, mq, "R11 stay high");
        lat_step(1'b1, 1'b0, mq, "R11 fall");
        lat_step(1'b1, 1'b0, mq, "R11 stay low");
        lat_step(1'b1, 1'b1, mq, "R11 rise again");

        // R1: reset from a set state
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check1("R1 re-reset q", {7'd0, lat_q}, 8'h00);
        check1("R1 re-reset vec_out", vec_out, 8'h00);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule